// File: doc/BRIEF.md
# Indexed Segment Address Sequencer

This block turns one indexed (gather or scatter) segment memory operation into an ordered stream of memory requests. It receives a base address, an element range, the number of fields per segment, and two independent width selects: one for the index elements and one for the data elements. For each active element it reads an index value and a mask bit through a shared element-select output. It then adds the zero-extended index to the base address and issues one request for every field of that element's segment.

Each operation runs in two passes. The probe pass issues a single request per active element. That request covers the element's whole segment footprint, so translation hardware outside the block can report a fault before any data moves. The access pass starts only after every probe has been accepted without a fault. It issues one request per field, and each request names the register-file slot that supplies or receives the data. Loads and stores use the same sequence and differ only in the direction bit on each request.

The request port uses valid/ready. Once a request is presented, every field is held stable until `req_ready` is sampled high, and one request is accepted per cycle in which both are high. `req_ready` may be held low for any number of cycles. The probe outcome is read from `probe_fault` in the cycle a probe is accepted. The memory, the register file and the translation unit all sit outside the block.

Top module: `idxseg_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `req_valid`, `done` and `fault` are low, and no request is presented while `busy` is low.
- R2: Only elements `vstart` to `vl-1` are processed. With `vm`=0, an element whose `mask_bit` reads 0 issues no request in either pass. With `vm`=1, the mask is ignored.
- R3: Field k of element i is addressed at `base` + zext(index[i]) + k·B, wrapping modulo 2^ADDR_W. B is the data element size in bytes (width code 0,1,2,3 = 1,2,4,8 bytes). The index is the low 8/16/32/64 bits of `idx_data` for index width code 0/1/2/3, zero-extended and then truncated to ADDR_W bits.
- R4: Each access-pass request carries `req_slot` = i + k·`vlmax`.
- R5: All probes (`req_probe`=1) are issued before any access request. A probe's address is `base` + zext(index[i]), its `req_len` is nf·B, and there is one probe per active element in ascending order. Access requests have `req_len` = B. Within the access pass, fields form the inner loop and elements the outer loop.
- R6: A probe accepted with `probe_fault`=1 ends the operation. No further request is issued, `done` pulses with `fault`=1, and `fault_elem` holds the faulting element number.
- R7: `req_write` equals the `is_store` value captured at `start` on every request of the operation. `req_size` carries the data width code.
- R8: While `req_valid` is high and `req_ready` is low, every request field stays unchanged in the next cycle.
- R9: `done` is a one-cycle pulse that comes after the last accepted request, with no request presented during it. A `start` received while `busy` is ignored.
- R10: An operation with `vstart` ≥ `vl` issues no request and still pulses `done` with `fault`=0.
- R11: All sixteen combinations of index width and data width produce the addresses and lengths of R3 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an operation when idle; captures all configuration |
| is_store | input | 1 | 1 = store (scatter), 0 = load (gather) |
| vm | input | 1 | 1 = unmasked, 0 = use `mask_bit` |
| base | input | ADDR_W | Base address |
| vstart | input | ELEM_W | First element number |
| vl | input | ELEM_W | One past the last element number |
| vlmax | input | ELEM_W | Slot stride between fields |
| nf | input | NF_W | Fields per segment, 1..8 (0 is taken as 1) |
| idx_wid | input | 2 | Index width code |
| dat_wid | input | 2 | Data width code |
| elem_sel | output | ELEM_W | Element number for the index and mask reads |
| idx_data | input | 64 | Raw index element for `elem_sel` (same cycle) |
| mask_bit | input | 1 | Mask bit for `elem_sel` (same cycle) |
| req_valid | output | 1 | Request presented |
| req_ready | input | 1 | Request accepted when high with `req_valid` |
| req_probe | output | 1 | 1 = probe request, 0 = access request |
| req_write | output | 1 | Direction of the request |
| req_addr | output | ADDR_W | Request address |
| req_size | output | 2 | Data width code |
| req_len | output | NF_W+4 | Request byte count |
| req_slot | output | ELEM_W+NF_W | Register-file slot for access requests |
| probe_fault | input | 1 | Fault result of a probe, read at acceptance |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Valid with `done`: operation ended by a probe fault |
| fault_elem | output | ELEM_W | Faulting element number, held until the next start |

## Verification
The bench builds the block at its default parameters: 32-bit addresses, 8-bit element numbers and 4-bit field counts. At this size a 64-bit index must be truncated and the address sum wraps past the top of the address space. An eight-field segment of 8-byte data makes the 64-byte probe length reachable. The bench runs every index/data width pairing and several masking and element-range cases. Its directed cases cover a probe fault in the middle of a pass, back-pressure on the request port, a start received while busy, a fully masked operation and an empty range.

// File: rtl/idxseg_pkg.sv
package idxseg_pkg;
  localparam int IDX_RAW_W = 64;

  typedef enum logic [1:0] {
    WID_8  = 2'd0,
    WID_16 = 2'd1,
    WID_32 = 2'd2,
    WID_64 = 2'd3
  } wid_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_ISSUE = 2'd2,
    ST_FIN   = 2'd3
  } st_e;

  // Byte count of one element of the given width code.
  function automatic logic [3:0] wid_bytes(wid_e w);
    return 4'd1 << w;
  endfunction
endpackage

// File: rtl/idxseg_index_ext.sv
module idxseg_index_ext
  import idxseg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  wid_e                 wid,
  input  logic [IDX_RAW_W-1:0] raw,
  output logic [ADDR_W-1:0]    offset
);
  logic [IDX_RAW_W-1:0] wide;

  // Zero-extend the selected low part of the raw index element.
  always_comb begin
    case (wid)
      WID_8:   wide = {56'd0, raw[7:0]};
      WID_16:  wide = {48'd0, raw[15:0]};
      WID_32:  wide = {32'd0, raw[31:0]};
      default: wide = raw;
    endcase
  end

  generate
    if (ADDR_W <= IDX_RAW_W) begin : g_trunc
      assign offset = wide[ADDR_W-1:0];
    end else begin : g_ext
      assign offset = {{(ADDR_W-IDX_RAW_W){1'b0}}, wide};
    end
  endgenerate
endmodule

// File: rtl/idxseg_addr_gen.sv
module idxseg_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int ELEM_W = 8,
  parameter int SLOT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] offset,
  input  logic [ELEM_W-1:0] elem,
  input  logic [ELEM_W-1:0] vlmax,
  input  logic [3:0]        stride,
  output logic [ADDR_W-1:0] addr,
  output logic [SLOT_W-1:0] slot
);
  // load: start of an element (field 0); step: advance to the next field.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      slot <= '0;
    end else if (load) begin
      addr <= base + offset;
      slot <= SLOT_W'(elem);
    end else if (step) begin
      addr <= addr + ADDR_W'(stride);
      slot <= slot + SLOT_W'(vlmax);
    end
  end
endmodule

// File: rtl/idxseg_ctrl.sv
module idxseg_ctrl
  import idxseg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ELEM_W = 8,
  parameter int NF_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_store,
  input  logic              vm,
  input  logic [ADDR_W-1:0] base,
  input  logic [ELEM_W-1:0] vstart,
  input  logic [ELEM_W-1:0] vl,
  input  logic [ELEM_W-1:0] vlmax,
  input  logic [NF_W-1:0]   nf,
  input  logic [1:0]        idx_wid,
  input  logic [1:0]        dat_wid,
  input  logic              mask_bit,
  input  logic              req_ready,
  input  logic              probe_fault,
  output logic [ELEM_W-1:0] elem,
  output logic              load,
  output logic              step,
  output logic              req_valid,
  output logic              probe_pass,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [ELEM_W-1:0] fault_elem,
  output logic              store_q,
  output logic [ADDR_W-1:0] base_q,
  output logic [ELEM_W-1:0] vlmax_q,
  output logic [NF_W-1:0]   nf_q,
  output wid_e              iw_q,
  output wid_e              dw_q
);
  st_e               st;
  logic [ELEM_W-1:0] elem_q, vstart_q, vl_q;
  logic [NF_W-1:0]   fld_q;
  logic              vm_q, fault_q;
  logic              at_end, active, last_fld;

  assign at_end   = elem_q >= vl_q;
  assign active   = vm_q | mask_bit;
  assign last_fld = fld_q == nf_q - NF_W'(1);

  assign elem       = elem_q;
  assign req_valid  = st == ST_ISSUE;
  assign busy       = st != ST_IDLE;
  assign done       = st == ST_FIN;
  assign fault      = done & fault_q;
  assign load       = (st == ST_LOOK) && !at_end && active;
  assign step       = req_valid && req_ready && !probe_pass && !last_fld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      elem_q     <= '0;
      vstart_q   <= '0;
      vl_q       <= '0;
      vlmax_q    <= '0;
      nf_q       <= NF_W'(1);
      fld_q      <= '0;
      vm_q       <= 1'b1;
      store_q    <= 1'b0;
      base_q     <= '0;
      iw_q       <= WID_8;
      dw_q       <= WID_8;
      probe_pass <= 1'b1;
      fault_q    <= 1'b0;
      fault_elem <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            elem_q     <= vstart;
            vstart_q   <= vstart;
            vl_q       <= vl;
            vlmax_q    <= vlmax;
            nf_q       <= (nf == '0) ? NF_W'(1) : nf;
            vm_q       <= vm;
            store_q    <= is_store;
            base_q     <= base;
            iw_q       <= wid_e'(idx_wid);
            dw_q       <= wid_e'(dat_wid);
            probe_pass <= 1'b1;
            fault_q    <= 1'b0;
            st         <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (at_end) begin
            if (probe_pass) begin
              probe_pass <= 1'b0;
              elem_q     <= vstart_q;
            end else begin
              st <= ST_FIN;
            end
          end else if (!active) begin
            elem_q <= elem_q + ELEM_W'(1);
          end else begin
            fld_q <= '0;
            st    <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (req_ready) begin
            if (probe_pass) begin
              if (probe_fault) begin
                fault_q    <= 1'b1;
                fault_elem <= elem_q;
                st         <= ST_FIN;
              end else begin
                elem_q <= elem_q + ELEM_W'(1);
                st     <= ST_LOOK;
              end
            end else if (last_fld) begin
              elem_q <= elem_q + ELEM_W'(1);
              st     <= ST_LOOK;
            end else begin
              fld_q <= fld_q + NF_W'(1);
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idxseg_seq.sv
module idxseg_seq
  import idxseg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ELEM_W = 8,
  parameter int NF_W   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   is_store,
  input  logic                   vm,
  input  logic [ADDR_W-1:0]      base,
  input  logic [ELEM_W-1:0]      vstart,
  input  logic [ELEM_W-1:0]      vl,
  input  logic [ELEM_W-1:0]      vlmax,
  input  logic [NF_W-1:0]        nf,
  input  logic [1:0]             idx_wid,
  input  logic [1:0]             dat_wid,
  output logic [ELEM_W-1:0]      elem_sel,
  input  logic [63:0]            idx_data,
  input  logic                   mask_bit,
  output logic                   req_valid,
  input  logic                   req_ready,
  output logic                   req_probe,
  output logic                   req_write,
  output logic [ADDR_W-1:0]      req_addr,
  output logic [1:0]             req_size,
  output logic [NF_W+3:0]        req_len,
  output logic [ELEM_W+NF_W-1:0] req_slot,
  input  logic                   probe_fault,
  output logic                   busy,
  output logic                   done,
  output logic                   fault,
  output logic [ELEM_W-1:0]      fault_elem
);
  localparam int SLOT_W = ELEM_W + NF_W;
  localparam int LEN_W  = NF_W + 4;

  logic              load, step, probe_pass, store_q;
  logic [ADDR_W-1:0] base_q, offset;
  logic [ELEM_W-1:0] vlmax_q;
  logic [NF_W-1:0]   nf_q;
  wid_e              iw_q, dw_q;
  logic [3:0]        dbytes;

  idxseg_ctrl #(.ADDR_W(ADDR_W), .ELEM_W(ELEM_W), .NF_W(NF_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store), .vm(vm),
    .base(base), .vstart(vstart), .vl(vl), .vlmax(vlmax), .nf(nf),
    .idx_wid(idx_wid), .dat_wid(dat_wid), .mask_bit(mask_bit),
    .req_ready(req_ready), .probe_fault(probe_fault),
    .elem(elem_sel), .load(load), .step(step), .req_valid(req_valid),
    .probe_pass(probe_pass), .busy(busy), .done(done), .fault(fault),
    .fault_elem(fault_elem), .store_q(store_q), .base_q(base_q),
    .vlmax_q(vlmax_q), .nf_q(nf_q), .iw_q(iw_q), .dw_q(dw_q)
  );

  idxseg_index_ext #(.ADDR_W(ADDR_W)) u_ext (
    .wid(iw_q), .raw(idx_data), .offset(offset)
  );

  assign dbytes = wid_bytes(dw_q);

  idxseg_addr_gen #(.ADDR_W(ADDR_W), .ELEM_W(ELEM_W), .SLOT_W(SLOT_W)) u_agen (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .base(base_q),
    .offset(offset), .elem(elem_sel), .vlmax(vlmax_q), .stride(dbytes),
    .addr(req_addr), .slot(req_slot)
  );

  assign req_probe = probe_pass;
  assign req_write = store_q;
  assign req_size  = dw_q;
  assign req_len   = probe_pass ? LEN_W'(nf_q) * LEN_W'(dbytes) : LEN_W'(dbytes);
endmodule

// File: rtl/idxseg_chk.sv
module idxseg_chk #(
  parameter int ADDR_W = 32,
  parameter int ELEM_W = 8,
  parameter int NF_W   = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   req_probe,
  input logic                   req_write,
  input logic [ADDR_W-1:0]      req_addr,
  input logic [1:0]             req_size,
  input logic [NF_W+3:0]        req_len,
  input logic [ELEM_W+NF_W-1:0] req_slot,
  input logic                   probe_fault,
  input logic                   busy,
  input logic                   done
);
  logic seen_acc, seen_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_acc   <= 1'b0;
      seen_fault <= 1'b0;
    end else if (done) begin
      seen_acc   <= 1'b0;
      seen_fault <= 1'b0;
    end else begin
      if (req_valid && req_ready && !req_probe) seen_acc <= 1'b1;
      if (req_valid && req_ready && req_probe && probe_fault) seen_fault <= 1'b1;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len)
      && $stable(req_slot) && $stable(req_probe) && $stable(req_size)));

  // R5
  probe_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_probe) |-> !seen_acc);

  // R6
  fault_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_fault |-> !req_valid);

  // R7
  dir_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(req_write));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);
endmodule

bind idxseg_seq idxseg_chk #(.ADDR_W(ADDR_W), .ELEM_W(ELEM_W), .NF_W(NF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_probe(req_probe), .req_write(req_write), .req_addr(req_addr),
  .req_size(req_size), .req_len(req_len), .req_slot(req_slot),
  .probe_fault(probe_fault), .busy(busy), .done(done)
);

// File: tb/idxseg_seq_bench.sv
`timescale 1ns/1ps
module idxseg_seq_bench;
  typedef struct packed {
    logic [1:0]  iw;
    logic [1:0]  dw;
    logic [3:0]  nf;
    logic [7:0]  vs;
    logic [7:0]  vl;
    logic [7:0]  vlmax;
    logic        vm;
    logic [15:0] mask;
    logic        st;
    logic [31:0] base;
    logic [1:0]  stall;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 4'd1, 8'd0, 8'd4, 8'd8,  1'b1, 16'hFFFF,  1'b0, 32'h0000_1000, 2'd0},
    '{2'd1, 2'd2, 4'd3, 8'd0, 8'd5, 8'd8,  1'b0, 16'h0016,  1'b0, 32'h2000_0000, 2'd1},
    '{2'd3, 2'd1, 4'd2, 8'd2, 8'd6, 8'd16, 1'b1, 16'h0000,  1'b1, 32'hFFFF_FF00, 2'd2},
    '{2'd2, 2'd3, 4'd8, 8'd0, 8'd2, 8'd4,  1'b1, 16'h0000,  1'b1, 32'h0000_0040, 2'd0},
    '{2'd0, 2'd3, 4'd4, 8'd1, 8'd4, 8'd4,  1'b0, 16'h000A,  1'b0, 32'h0000_8000, 2'd1},
    '{2'd2, 2'd0, 4'd2, 8'd3, 8'd3, 8'd8,  1'b1, 16'h0000,  1'b0, 32'h0000_0100, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, is_store = 1'b0, vm = 1'b1;
  logic [31:0] base = '0;
  logic [7:0]  vstart = '0, vl = '0, vlmax = '0;
  logic [3:0]  nf = 4'd1;
  logic [1:0]  idx_wid = '0, dat_wid = '0;
  logic [7:0]  elem_sel;
  logic [63:0] idx_data;
  logic        mask_bit;
  logic [15:0] mask_pat = '0;
  logic        req_valid, req_ready = 1'b0, req_probe, req_write;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic [7:0]  req_len;
  logic [11:0] req_slot;
  logic        probe_fault = 1'b0;
  logic        busy, done, fault;
  logic [7:0]  fault_elem;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  idxseg_seq u_idxseg_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store), .vm(vm),
    .base(base), .vstart(vstart), .vl(vl), .vlmax(vlmax), .nf(nf),
    .idx_wid(idx_wid), .dat_wid(dat_wid), .elem_sel(elem_sel),
    .idx_data(idx_data), .mask_bit(mask_bit), .req_valid(req_valid),
    .req_ready(req_ready), .req_probe(req_probe), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_len(req_len),
    .req_slot(req_slot), .probe_fault(probe_fault), .busy(busy),
    .done(done), .fault(fault), .fault_elem(fault_elem)
  );

  function automatic logic [63:0] raw_of(int e);
    return {24'hF1E2D3, 8'(e * 3), 8'h9A, 8'h7B, 8'(e * 5 + 1), 8'(e * 11 + 2)};
  endfunction

  function automatic logic [31:0] off_of(int e, int iw);
    logic [63:0] r = raw_of(e);
    case (iw)
      0: r = r & 64'hFF;
      1: r = r & 64'hFFFF;
      2: r = r & 64'hFFFF_FFFF;
      default: ;
    endcase
    return r[31:0];
  endfunction

  assign idx_data = raw_of(int'(elem_sel));
  assign mask_bit = mask_pat[elem_sel[3:0]];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // Wait (at negedges) for a presented request; returns 0 on timeout.
  task automatic wait_req(output bit got);
    got = 1'b0;
    for (int t = 0; t < 100; t++) begin
      if (req_valid) begin got = 1'b1; return; end
      @(negedge clk);
    end
  endtask

  task automatic run_op(vec_t v, int fault_at, bit poke, string tag);
    bit got, stop, seen_done;
    int bytes;
    bytes = 1 << v.dw;
    stop = 1'b0;
    @(negedge clk);
    idx_wid = v.iw; dat_wid = v.dw; nf = v.nf; vstart = v.vs; vl = v.vl;
    vlmax = v.vlmax; vm = v.vm; mask_pat = v.mask; is_store = v.st; base = v.base;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int p = 0; p < 2 && !stop; p++) begin
      for (int e = int'(v.vs); e < int'(v.vl) && !stop; e++) begin
        if (!(v.vm || v.mask[e])) continue;
        for (int k = 0; k < (p == 0 ? 1 : int'(v.nf)) && !stop; k++) begin
          logic [31:0] ea;
          wait_req(got);
          check(got, "R2", {tag, " request presented"}, got, 1);
          if (!got) begin stop = 1'b1; break; end
          ea = v.base + off_of(e, v.iw) + 32'(k * bytes);
          check(req_probe == (p == 0), "R5", {tag, " pass order"}, req_probe, p == 0);
          check(req_addr == ea, p == 0 ? "R5" : "R3", {tag, " address"}, req_addr, ea);
          check(req_len == 8'(p == 0 ? int'(v.nf) * bytes : bytes), "R5", {tag, " length"},
                req_len, p == 0 ? int'(v.nf) * bytes : bytes);
          if (p == 1)
            check(req_slot == 12'(e + k * int'(v.vlmax)), "R4", {tag, " slot"},
                  req_slot, e + k * int'(v.vlmax));
          check(req_write == v.st && req_size == v.dw, "R7", {tag, " direction/size"},
                {req_write, req_size}, {v.st, v.dw});
          if (poke) begin
            start = 1'b1; base = ~v.base;
            @(negedge clk);
            start = 1'b0; base = v.base;
            poke = 1'b0;
          end
          if (v.stall != 0) begin
            logic [31:0] a0 = req_addr;
            repeat (int'(v.stall)) @(negedge clk);
            check(req_valid && req_addr == a0, "R8", {tag, " held under stall"}, req_addr, a0);
          end
          req_ready = 1'b1;
          probe_fault = (p == 0 && e == fault_at);
          @(negedge clk);
          req_ready = 1'b0;
          probe_fault = 1'b0;
          if (p == 0 && e == fault_at) stop = 1'b1;
        end
      end
    end
    seen_done = 1'b0;
    for (int t = 0; t < 50; t++) begin
      if (req_valid) begin
        check(0, "R9", {tag, " extra request"}, req_addr, 0);
        req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
      end else if (done) begin
        seen_done = 1'b1; break;
      end else @(negedge clk);
    end
    check(seen_done, "R9", {tag, " done seen"}, seen_done, 1);
    check(fault == (fault_at >= 0), "R6", {tag, " fault flag"}, fault, fault_at >= 0);
    if (fault_at >= 0)
      check(fault_elem == 8'(fault_at), "R6", {tag, " fault element"}, fault_elem, fault_at);
    @(negedge clk);
    check(!done && !busy, "R9", {tag, " done one cycle"}, done, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !req_valid && !done && !fault, "R1", "reset outputs",
          {busy, req_valid, done, fault}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !req_valid, "R1", "idle after reset", {busy, req_valid}, 0);

    // Table walk: R2 R3 R4 R5 R7 R8 R10
    for (int i = 0; i < NV; i++) run_op(VECS[i], -1, 1'b0, $sformatf("vec%0d", i));

    // R11 every index/data width pairing
    for (int c = 0; c < 16; c++) begin
      vec_t v;
      v = '{2'(c >> 2), 2'(c), 4'd2, 8'd0, 8'd2, 8'd4, 1'b1, 16'h0, 1'(c), 32'h3000, 2'd0};
      run_op(v, -1, 1'b0, $sformatf("R11 combo%0d", c));
    end

    // R6 fault on element 2 mid-probe pass
    run_op(VECS[1], 2, 1'b0, "R6 fault");
    // R9 start while busy ignored
    run_op(VECS[0], -1, 1'b1, "R9 restart");
    // R2 fully masked operation issues nothing
    run_op('{2'd0, 2'd0, 4'd2, 8'd0, 8'd3, 8'd4, 1'b0, 16'h0, 1'b0, 32'h10, 2'd0},
           -1, 1'b0, "R2 allmasked");
    // R10 vstart beyond vl
    run_op('{2'd1, 2'd1, 4'd1, 8'd7, 8'd4, 8'd8, 1'b1, 16'h0, 1'b1, 32'h20, 2'd0},
           -1, 1'b0, "R10 empty");
    summary();
  end
endmodule